// File: doc/BRIEF.md
# Line-Decoded Data Packet Receiver with Handshake Request

This block sits behind a serial physical layer. It takes one sampled line level per bit strobe and turns level changes back into bits. While idle it watches the decoded stream for a start pattern. Once that pattern is seen, it captures the packet identifier byte. From then on it assembles bytes and runs a 16-bit cyclic check over every bit until an end-of-packet strobe arrives.

The last two bytes before the end strobe belong to the check field and are never delivered. Every earlier byte goes out on a byte-wide strobe, with a two-byte delay. When the packet closes, the block raises either a good flag or a bad flag. At the same moment it may request a one-word reply code for a separate reply serialiser. The reply is acknowledge, negative acknowledge (which asks the sender to resend) or halted. A transfer-type input marks real-time transfers. These never get a reply, so a damaged real-time packet is only flagged bad and is never resent.

Top module: `nrzi_pkt_rx`

## Requirements
- R1: On each `bit_valid` strobe the decoded bit is 0 when `line_in` differs from the level at the previous strobe, and 1 when it is the same. The remembered level is 1 after reset.
- R2: A packet starts only after the decoded stream shows seven 0 bits followed by a 1. The next 8 bits, least significant first, form the identifier byte, which appears on `pid_out` together with the end flag.
- R3: After the identifier, bits are packed least significant first into bytes. Every byte except the final two is delivered in arrival order on `byte_data`, each with a one-cycle `byte_valid` pulse.
- R4: The check runs over all bits after the identifier, including the final 16. The register starts at all ones, shifts left, and XORs in 16'h8005 when the incoming bit differs from the register's top bit. The check passes when the register ends at 16'h800D.
- R5: A packet that passes every check, is not real-time and has `halt` low requests reply code 2'b00 (acknowledge).
- R6: A bad packet that is not real-time, has `halt` low and has a valid identifier requests reply code 2'b01 (negative acknowledge).
- R7: When `halt` is high at the end strobe, a non-real-time packet with a valid identifier requests code 2'b10 (halted), whatever its check result.
- R8: When `iso` is high at the end strobe, no reply is requested, and the packet is still flagged good or bad.
- R9: An identifier whose upper nibble is not the bitwise complement of its lower nibble makes the packet bad, and no reply is requested.
- R10: At most 64 payload bytes are delivered. A packet carrying more is an overflow: it is flagged bad and handled like a check failure.
- R11: A packet that ends mid-byte, or with fewer than 16 bits after the identifier, is flagged bad. An end strobe before the identifier is complete flags the packet bad with no reply.
- R12: After reset, `byte_valid`, `pkt_good`, `pkt_bad` and `hs_valid` are all low.
- R13: Each end strobe after a start pattern gives exactly one of `pkt_good` or `pkt_bad`, one cycle later. An end strobe while still searching for the start pattern gives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One sampled line level is present on `line_in` |
| line_in | input | 1 | Sampled line level |
| eop | input | 1 | End-of-packet strobe; a bit on the same cycle is not taken into the packet |
| iso | input | 1 | Real-time transfer, sampled at `eop` |
| halt | input | 1 | Endpoint halted, sampled at `eop` |
| byte_valid | output | 1 | Payload byte strobe |
| byte_data | output | 8 | Payload byte |
| pkt_good | output | 1 | Packet passed all checks (one-cycle pulse) |
| pkt_bad | output | 1 | Packet failed a check (one-cycle pulse) |
| pid_out | output | 8 | Identifier byte, valid with the end flags |
| hs_valid | output | 1 | Reply request strobe |
| hs_code | output | 2 | Reply code: 00 acknowledge, 01 negative acknowledge, 10 halted |

## Verification
The sweeps cover payload lengths from empty up to one byte past the cap. A receiver that releases the check bytes as payload, or that releases the wrong bytes, delivers extra or shifted bytes. A receiver with an off-by-one cap delivers 65 bytes or flags a 64-byte packet as overflow. Each of the 16 check bits is flipped in turn, so a weakened check would acknowledge a damaged packet. Every combination of real-time, halt and damage is run, and any mix-up in reply precedence shows up as a missing reply, an extra reply or a wrong code. Further cases cover a line that carries noise before the start pattern, a stream that is one zero short of the pattern, a packet cut off inside the identifier, and a packet cut off inside a byte. A receiver that locks onto a false start, or that stays silent on a broken packet, fails these.

// File: rtl/nrzi_pkt_rx_pkg.sv
package nrzi_pkt_rx_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      HS_ACK   = 2'b00,
      HS_NAK   = 2'b01,
      HS_STALL = 2'b10
   } hs_code_e;

   typedef enum logic [1:0] {
      ST_HUNT = 2'b00,
      ST_PID  = 2'b01,
      ST_DATA = 2'b10
   } rx_state_e;

endpackage

// File: rtl/nrzi_line_dec.sv
module nrzi_line_dec #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic samp,
   input  logic line,
   output logic bit_out
);

   logic prev_lvl;

   // unchanged level decodes as 1, a change as 0
   assign bit_out = ~(line ^ prev_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n)
         prev_lvl <= IDLE_LEVEL;
      else if (samp)
         prev_lvl <= line;
   end

endmodule

// File: rtl/serial_crc_chk.sv
module serial_crc_chk #(
   parameter int          W       = 16,
   parameter logic [W-1:0] POLY    = 16'h8005,
   parameter logic [W-1:0] INIT    = 16'hFFFF,
   parameter logic [W-1:0] RESIDUE = 16'h800D
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic en,
   input  logic din,
   output logic match
);

   logic [W-1:0] reg_q;
   logic         fb;

   assign fb    = din ^ reg_q[W-1];
   assign match = (reg_q == RESIDUE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         reg_q <= INIT;
      else if (init)
         reg_q <= INIT;
      else if (en)
         reg_q <= {reg_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

endmodule

// File: rtl/byte_holdback.sv
module byte_holdback #(
   parameter int W       = 8,
   parameter int DEPTH   = 2,
   parameter int MAX_OUT = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         out_valid,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         ovf
);

   localparam int FW = $clog2(DEPTH + 1);
   localparam int CW = $clog2(MAX_OUT + 1);

   logic [W-1:0]  tail;
   logic [FW-1:0] fill;
   logic [CW-1:0] pcnt;

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] h;
         always_ff @(posedge clk) begin
            if (!rst_n)
               h <= '0;
            else if (push)
               h <= din;
         end
         assign tail = h;
      end else begin : g_chain
         logic [W-1:0] h [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) h[i] <= '0;
            end else if (push) begin
               h[0] <= din;
               for (int i = 1; i < DEPTH; i++) h[i] <= h[i-1];
            end
         end
         assign tail = h[DEPTH-1];
      end
   endgenerate

   assign full = (fill == FW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill      <= '0;
         pcnt      <= '0;
         ovf       <= 1'b0;
         out_valid <= 1'b0;
         dout      <= '0;
      end else begin
         out_valid <= 1'b0;
         if (clr) begin
            fill <= '0;
            pcnt <= '0;
            ovf  <= 1'b0;
         end else if (push) begin
            if (!full)
               fill <= fill + 1'b1;
            else if (pcnt == CW'(MAX_OUT))
               ovf <= 1'b1;
            else begin
               out_valid <= 1'b1;
               dout      <= tail;
               pcnt      <= pcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/nrzi_pkt_rx.sv
module nrzi_pkt_rx
   import nrzi_pkt_rx_pkg::*;
#(
   parameter int                 SYNC_W      = 8,
   parameter logic [SYNC_W-1:0]  SYNC_PAT    = 8'h80,
   parameter int                 MAX_PAYLOAD = 64,
   parameter int                 CRC_W       = 16,
   parameter logic [CRC_W-1:0]   CRC_POLY    = 16'h8005,
   parameter logic [CRC_W-1:0]   CRC_INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0]   CRC_RESIDUE = 16'h800D,
   parameter logic               IDLE_LEVEL  = 1'b1,
   parameter bit                 CHECK_PID   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bit_valid,
   input  logic        line_in,
   input  logic        eop,
   input  logic        iso,
   input  logic        halt,
   output logic        byte_valid,
   output logic [7:0]  byte_data,
   output logic        pkt_good,
   output logic        pkt_bad,
   output logic [7:0]  pid_out,
   output logic        hs_valid,
   output logic [1:0]  hs_code
);

   localparam int HOLD  = CRC_W / BYTE_W;
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   initial begin
      assert (CRC_W % BYTE_W == 0 && CRC_W >= BYTE_W)
         else $fatal(1, "check width must be a whole number of bytes");
      assert (MAX_PAYLOAD >= 1) else $fatal(1, "payload cap must be positive");
      assert (SYNC_W >= 2) else $fatal(1, "start pattern too short");
   end

   logic dbit;
   logic dvalid;

   nrzi_line_dec #(.IDLE_LEVEL(IDLE_LEVEL)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp    (bit_valid),
      .line    (line_in),
      .bit_out (dbit)
   );

   assign dvalid = bit_valid & ~eop;

   rx_state_e             st;
   logic [SYNC_W-2:0]     sync_sr;
   logic [SYNC_W-1:0]     sync_nxt;
   logic [BYTE_W-2:0]     sh;
   logic [BYTE_W-1:0]     sh_nxt;
   logic [CNT_W-1:0]      cnt;
   logic [BYTE_W-1:0]     pid_q;
   logic                  pid_done;
   logic                  push;
   logic                  crc_en;
   logic                  crc_ok;
   logic                  hold_full;
   logic                  hold_ovf;
   logic                  pid_ok;
   logic                  pkt_ok;
   hs_code_e              hs_q;

   assign sync_nxt = {dbit, sync_sr};
   assign sh_nxt   = {dbit, sh};
   assign pid_done = (st == ST_PID)  && dvalid && (cnt == LAST_BIT);
   assign push     = (st == ST_DATA) && dvalid && (cnt == LAST_BIT);
   assign crc_en   = (st == ST_DATA) && dvalid;

   serial_crc_chk #(
      .W       (CRC_W),
      .POLY    (CRC_POLY),
      .INIT    (CRC_INIT),
      .RESIDUE (CRC_RESIDUE)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (pid_done),
      .en    (crc_en),
      .din   (dbit),
      .match (crc_ok)
   );

   byte_holdback #(
      .W       (BYTE_W),
      .DEPTH   (HOLD),
      .MAX_OUT (MAX_PAYLOAD)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pid_done),
      .push      (push),
      .din       (sh_nxt),
      .out_valid (byte_valid),
      .dout      (byte_data),
      .full      (hold_full),
      .ovf       (hold_ovf)
   );

   generate
      if (CHECK_PID) begin : g_pid_chk
         assign pid_ok = (pid_q[BYTE_W-1:BYTE_W/2] == ~pid_q[BYTE_W/2-1:0]);
      end else begin : g_pid_any
         assign pid_ok = 1'b1;
      end
   endgenerate

   assign pkt_ok  = pid_ok & crc_ok & hold_full & ~hold_ovf & (cnt == '0);
   assign hs_code = hs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_HUNT;
         sync_sr  <= '1;
         sh       <= '0;
         cnt      <= '0;
         pid_q    <= '0;
         pkt_good <= 1'b0;
         pkt_bad  <= 1'b0;
         pid_out  <= '0;
         hs_valid <= 1'b0;
         hs_q     <= HS_ACK;
      end else begin
         pkt_good <= 1'b0;
         pkt_bad  <= 1'b0;
         hs_valid <= 1'b0;
         if (eop) begin
            unique case (st)
               ST_PID: begin
                  pkt_bad <= 1'b1;
                  pid_out <= '0;
               end
               ST_DATA: begin
                  pkt_good <= pkt_ok;
                  pkt_bad  <= ~pkt_ok;
                  pid_out  <= pid_q;
                  if (pid_ok && !iso) begin
                     hs_valid <= 1'b1;
                     if (halt)
                        hs_q <= HS_STALL;
                     else if (pkt_ok)
                        hs_q <= HS_ACK;
                     else
                        hs_q <= HS_NAK;
                  end
               end
               default: ;
            endcase
            st      <= ST_HUNT;
            sync_sr <= '1;
         end else if (dvalid) begin
            unique case (st)
               ST_HUNT: begin
                  if (sync_nxt == SYNC_PAT) begin
                     st      <= ST_PID;
                     cnt     <= '0;
                     sync_sr <= '1;
                  end else begin
                     sync_sr <= sync_nxt[SYNC_W-1:1];
                  end
               end
               ST_PID: begin
                  sh  <= sh_nxt[BYTE_W-1:1];
                  cnt <= cnt + 1'b1;
                  if (cnt == LAST_BIT) begin
                     pid_q <= sh_nxt;
                     st    <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  sh  <= sh_nxt[BYTE_W-1:1];
                  cnt <= cnt + 1'b1;
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/nrzi_pkt_rx_chk.sv
module nrzi_pkt_rx_chk #(
   parameter int MAX_PAYLOAD = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       eop,
   input logic       iso,
   input logic       halt,
   input logic       byte_valid,
   input logic       pkt_good,
   input logic       pkt_bad,
   input logic       hs_valid,
   input logic [1:0] hs_code
);

   localparam int BW = $clog2(MAX_PAYLOAD + 2);

   logic [BW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bcnt <= '0;
      else if (pkt_good || pkt_bad)
         bcnt <= '0;
      else if (byte_valid && bcnt != '1)
         bcnt <= bcnt + 1'b1;
   end

   assert_flags_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_good && pkt_bad));

   assert_flag_follows_eop_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_good || pkt_bad) |-> $past(eop));

   assert_reply_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> (pkt_good || pkt_bad));

   assert_no_reply_realtime_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> !$past(iso));

   assert_halt_gives_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && $past(halt)) |-> (hs_code == 2'b10));

   assert_ack_only_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'b00) |-> pkt_good);

   assert_nak_only_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && hs_code == 2'b01) |-> pkt_bad);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (bcnt < BW'(MAX_PAYLOAD)));

endmodule

bind nrzi_pkt_rx nrzi_pkt_rx_chk #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eop        (eop),
   .iso        (iso),
   .halt       (halt),
   .byte_valid (byte_valid),
   .pkt_good   (pkt_good),
   .pkt_bad    (pkt_bad),
   .hs_valid   (hs_valid),
   .hs_code    (hs_code)
);

// File: tb/nrzi_pkt_rx_test.sv
module nrzi_pkt_rx_test;

   localparam int MAXP = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0;
   logic       line_in = 1'b1;
   logic       eop = 1'b0;
   logic       iso = 1'b0;
   logic       halt = 1'b0;
   logic       byte_valid;
   logic [7:0] byte_data;
   logic       pkt_good;
   logic       pkt_bad;
   logic [7:0] pid_out;
   logic       hs_valid;
   logic [1:0] hs_code;

   nrzi_pkt_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_valid  (bit_valid),
      .line_in    (line_in),
      .eop        (eop),
      .iso        (iso),
      .halt       (halt),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .pkt_good   (pkt_good),
      .pkt_bad    (pkt_bad),
      .pid_out    (pid_out),
      .hs_valid   (hs_valid),
      .hs_code    (hs_code)
   );

   always #4 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] got [0:127];
   int         n_got;
   int         n_good;
   int         n_badf;
   int         n_hs;
   logic [1:0] last_hs;
   logic [7:0] last_pid;

   logic bq [0:1023];
   int   nq = 0;
   logic lvl = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid) begin
            if (n_got < 128) got[n_got] = byte_data;
            n_got++;
         end
         if (pkt_good) n_good++;
         if (pkt_bad)  n_badf++;
         if (pkt_good || pkt_bad) last_pid = pid_out;
         if (hs_valid) begin
            n_hs++;
            last_hs = hs_code;
         end
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clr_mon();
      n_got = 0; n_good = 0; n_badf = 0; n_hs = 0;
   endtask

   task automatic put_bit(input logic b);
      bq[nq] = b;
      nq++;
   endtask

   task automatic put_byte(input logic [7:0] b8);
      for (int i = 0; i < 8; i++) put_bit(b8[i]);
   endtask

   task automatic drive_all();
      for (int i = 0; i < nq; i++) begin
         @(negedge clk);
         if (bq[i] == 1'b0) lvl = ~lvl;
         line_in   = lvl;
         bit_valid = 1'b1;
         @(negedge clk);
         bit_valid = 1'b0;
      end
      @(negedge clk);
      eop = 1'b1;
      @(negedge clk);
      eop = 1'b0;
      repeat (4) @(negedge clk);
      nq = 0;
   endtask

   task automatic run_pkt(input string req, input logic [7:0] pid, input int len,
                          input int crc_flip, input int extra, input logic isov,
                          input logic haltv, input int seed, input bit noisy);
      logic [7:0]  pl [0:127];
      logic [15:0] c;
      logic [15:0] tx;
      logic        fb;
      bit          pidok;
      bit          good;
      int          exp_n;
      int          mism;
      int          code;
      for (int i = 0; i < len; i++) pl[i] = 8'(seed * 37 + i * 11 + 5);
      c = 16'hFFFF;
      for (int i = 0; i < len; i++) begin
         for (int k = 0; k < 8; k++) begin
            fb = pl[i][k] ^ c[15];
            c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
         end
      end
      tx = ~c;
      if (crc_flip >= 0) tx[15 - crc_flip] = ~tx[15 - crc_flip];
      nq = 0;
      if (noisy) begin
         put_bit(1); put_bit(0); put_bit(1); put_bit(1);
         put_bit(0); put_bit(0); put_bit(1);
      end
      put_byte(8'h80);
      put_byte(pid);
      for (int i = 0; i < len; i++) put_byte(pl[i]);
      for (int k = 15; k >= 0; k--) put_bit(tx[k]);
      for (int e = 0; e < extra; e++) put_bit(1'b1);
      iso  = isov;
      halt = haltv;
      clr_mon();
      drive_all();
      iso  = 1'b0;
      halt = 1'b0;

      pidok = (pid[7:4] == ~pid[3:0]);
      good  = pidok && (crc_flip < 0) && (len <= MAXP) && (extra == 0);
      exp_n = (len > MAXP) ? MAXP : len;
      check_eq(req, "payload byte count", n_got, exp_n);
      mism = 0;
      for (int i = 0; i < exp_n && i < n_got; i++)
         if (got[i] != pl[i]) mism++;
      check_eq(req, "payload mismatches", mism, 0);
      check_eq(req, "good flags", n_good, good ? 1 : 0);
      check_eq(req, "bad flags", n_badf, good ? 0 : 1);
      if (good) check_eq(req, "identifier", int'(last_pid), int'(pid));
      if (pidok && !isov) begin
         code = haltv ? 2 : (good ? 0 : 1);
         check_eq(req, "reply count", n_hs, 1);
         check_eq(req, "reply code", int'(last_hs), code);
      end else begin
         check_eq(req, "reply count", n_hs, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      clr_mon();
      repeat (3) @(negedge clk);
      // R12: outputs quiet in and after reset
      check_eq("R12", "byte_valid", int'(byte_valid), 0);
      check_eq("R12", "pkt flags", int'(pkt_good) + int'(pkt_bad), 0);
      check_eq("R12", "hs_valid", int'(hs_valid), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R12", "outputs after release",
               int'(byte_valid) + int'(pkt_good) + int'(pkt_bad) + int'(hs_valid), 0);

      // R1 R3 R4 R5: length sweep of good packets
      for (int len = 0; len <= 8; len++)
         run_pkt("R1/R3/R4/R5", 8'hC3, len, -1, 0, 1'b0, 1'b0, len, 1'b0);

      // R10: at and beyond the payload cap
      run_pkt("R10", 8'h4B, MAXP, -1, 0, 1'b0, 1'b0, 3, 1'b0);
      run_pkt("R10", 8'h4B, MAXP + 1, -1, 0, 1'b0, 1'b0, 4, 1'b0);
      run_pkt("R10/R8", 8'hC3, MAXP + 6, -1, 0, 1'b1, 1'b0, 5, 1'b0);

      // R5 R6 R7 R8: every mix of real-time, halt and damage
      for (int m = 0; m < 8; m++)
         run_pkt("R5/R6/R7/R8", 8'hD2, 3, (m & 1) ? 7 : -1, 0,
                 1'((m >> 1) & 1), 1'((m >> 2) & 1), m + 9, 1'b0);

      // R4 R6: each check bit damaged in turn
      for (int b = 0; b < 16; b++)
         run_pkt("R4/R6", 8'hC3, 2, b, 0, 1'b0, 1'b0, b + 20, 1'b0);

      // R9: bad identifier under every reply condition
      for (int m = 0; m < 4; m++)
         run_pkt("R9", 8'hC4, 2, -1, 0, 1'((m >> 0) & 1), 1'((m >> 1) & 1), m, 1'b0);

      // R11: stray bits after the check field
      for (int e = 1; e < 8; e++)
         run_pkt("R11", 8'hC3, 1, -1, e, 1'b0, 1'b0, e + 40, 1'b0);

      // R1 R2: line noise ahead of the start pattern
      run_pkt("R1/R2", 8'h5A, 4, -1, 0, 1'b0, 1'b0, 77, 1'b1);

      // R11: packet ends after a single data byte
      nq = 0;
      put_byte(8'h80); put_byte(8'hC3); put_byte(8'h5A);
      clr_mon();
      drive_all();
      check_eq("R11", "short bytes", n_got, 0);
      check_eq("R11", "short bad flag", n_badf, 1);
      check_eq("R11", "short reply code", (n_hs == 1) ? int'(last_hs) : -1, 1);

      // R11 R13: packet ends inside the identifier
      nq = 0;
      put_byte(8'h80); put_bit(1); put_bit(0); put_bit(1); put_bit(1);
      clr_mon();
      drive_all();
      check_eq("R11", "cut identifier bad flag", n_badf, 1);
      check_eq("R13", "cut identifier good flag", n_good, 0);
      check_eq("R11", "cut identifier reply", n_hs, 0);

      // R2 R13: one zero short of the start pattern, end strobe while searching
      nq = 0;
      for (int i = 0; i < 6; i++) put_bit(1'b0);
      put_bit(1'b1);
      for (int i = 0; i < 16; i++) put_bit(1'b1);
      clr_mon();
      drive_all();
      check_eq("R2", "no packet bytes", n_got, 0);
      check_eq("R13", "no packet flags", n_good + n_badf + n_hs, 0);

      // R5: receiver recovers and accepts a clean packet afterwards
      run_pkt("R5/R13", 8'hE1, 5, -1, 0, 1'b0, 1'b0, 99, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule